// File: doc/BRIEF.md
# Boot Image Chunk Scanner

This block searches the start of a NAND device for a bootable image and loads it into memory. It reads the device one 264-byte chunk at a time through an abstract chunk reader. The reader takes a chunk index over a valid/ready request. It then returns the 256 payload bytes as a stream, and reports on the last byte whether ECC corrected the chunk or found an uncorrectable error. The ECC bytes themselves never reach this block. The scanner looks for an image header and copies the image into a byte-wide memory write port at the load address that the header gives. It checks the image CRC, then reports success together with the entry address.

The scanner has two modes: header hunting and image loading. A bad chunk or a CRC mismatch sends it back to hunting at the next chunk. The search covers a fixed window of chunks, 16384 by default (4 MB of payload). A select input, sampled at start, picks either the main image or the failsafe image. If the main search fails, the scanner repeats the search once for the failsafe image. If the failsafe search also fails, the scanner halts with a fail flag that only reset clears.

Top module: `boot_image_scan`

## Requirements
- R1: After reset, busy, done, fail, rd_req_valid, mem_we and the three event pulses are all low.
- R2: A start pulse in idle samples sel_failsafe and requests chunk 0. Each later request asks for the previous index plus one, and a request stays asserted with a stable index until rd_req_ready is high.
- R3: A header occupies bytes 0..15 of a chunk, little-endian: the magic word in bytes 0..3, the load address in 4..7, the image length in bytes in 8..11 and the expected CRC in 12..15. The header is valid when its magic equals the selected image's magic and its length is nonzero. A good chunk with a valid header enters loading mode, and its 256 bytes are written to load address + 0..255.
- R4: In loading mode, each good chunk's 256 bytes are written at the next 256 consecutive addresses after the previous chunk's.
- R5: The image CRC is the reflected CRC-32 (polynomial 0x04C11DB7 reflected, preset all ones, output inverted). It covers image bytes 16 up to length-1, one byte per clock; bytes past the length have no effect on it.
- R6: Once the bytes accepted reach the length and the CRC matches, done rises and stays high. entry_addr holds the load address, and no further chunk is requested.
- R7: On a CRC mismatch, evt_crc_err pulses for one cycle and header hunting resumes with the next chunk.
- R8: An uncorrectable chunk in loading mode pulses evt_bad_block and returns to hunting at the next chunk. An uncorrectable chunk met while hunting is skipped with no pulse, even if it holds a valid header.
- R9: A chunk marked corrected but not uncorrectable is used as good data, and evt_corrected pulses once for it.
- R10: Chunk indices never exceed SCAN_CHUNKS-1. After that last chunk is processed without success, the attempt fails. An image that completes in that last chunk counts as success.
- R11: A failed main attempt restarts from chunk 0 searching for the failsafe magic, with on_failsafe high. A failed failsafe attempt, whether selected at start or reached by fallback, sets fail permanently, and later start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| sel_failsafe | input | 1 | Selects the failsafe image at start |
| rd_req_valid | output | 1 | Chunk read request valid |
| rd_req_ready | input | 1 | Reader accepts the request |
| rd_req_idx | output | IDX_W | Chunk index requested |
| rd_byte_valid | input | 1 | Payload byte valid |
| rd_byte | input | 8 | Payload byte |
| rd_byte_last | input | 1 | Last payload byte of the chunk |
| rd_ecc_corr | input | 1 | Chunk had corrected errors (with last byte) |
| rd_ecc_fail | input | 1 | Chunk uncorrectable (with last byte) |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Search in progress |
| done | output | 1 | Image loaded and verified |
| fail | output | 1 | Both permitted searches failed |
| entry_addr | output | ADDR_W | Load address of the verified image |
| on_failsafe | output | 1 | Current or final search targets the failsafe image |
| evt_corrected | output | 1 | One-cycle pulse: corrected chunk accepted |
| evt_bad_block | output | 1 | One-cycle pulse: uncorrectable chunk inside an image |
| evt_crc_err | output | 1 | One-cycle pulse: image CRC mismatch |

## Verification
The image-complete decision and the end of the search window can fall on the same chunk. This happens when an image's final chunk is the last index of the window. A directed case places an image there, and the run is judged correct only if done rises with the main image's entry address and neither fail nor the failsafe fallback occurs. The corrected-chunk pulse is also provoked on a chunk inside a loading image, so that the pulse and the continued loading are checked together.

// File: rtl/boot_scan_pkg.sv
package boot_scan_pkg;

   localparam int CHUNK_BYTES = 256;
   localparam int HDR_BYTES   = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_STREAM,
      ST_EVAL,
      ST_FLUSH,
      ST_COMMIT,
      ST_NEXT,
      ST_HALT
   } scan_st_e;

   // byte 0 of the header sits in the least significant bits
   typedef struct packed {
      logic [31:0] crc;
      logic [31:0] len;
      logic [31:0] load;
      logic [31:0] magic;
   } img_hdr_t;

endpackage

// File: rtl/scan_crc32.sv
module scan_crc32 #(
   parameter int          BITS_PER_STEP = 8,
   parameter logic [31:0] POLY_REFL     = 32'hEDB8_8320
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic [BITS_PER_STEP-1:0] din,
   output logic [31:0]              crc_q
);
   if (BITS_PER_STEP < 1 || BITS_PER_STEP > 32) begin : g_bad_step
      $error("scan_crc32: BITS_PER_STEP out of range");
   end

   logic [31:0] stage [0:BITS_PER_STEP];

   assign stage[0] = crc_q ^ {{(32-BITS_PER_STEP){1'b0}}, din};

   for (genvar b = 0; b < BITS_PER_STEP; b++) begin : g_shift
      assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY_REFL)
                                      : (stage[b] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '1;
      else if (clr) crc_q <= '1;
      else if (en)  crc_q <= stage[BITS_PER_STEP];
   end
endmodule

// File: rtl/scan_hdr_latch.sv
module scan_hdr_latch
   import boot_scan_pkg::*;
#(
   parameter int  NBYTES = HDR_BYTES,
   localparam int POS_W  = $clog2(NBYTES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [POS_W-1:0] pos,
   input  logic [7:0]       din,
   output logic [8*NBYTES-1:0] raw
);
   if (NBYTES != HDR_BYTES) begin : g_bad_size
      $error("scan_hdr_latch: header size must match the packed header type");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  raw <= '0;
      else if (en) raw[pos*8 +: 8] <= din;
   end
endmodule

// File: rtl/boot_image_scan.sv
module boot_image_scan
   import boot_scan_pkg::*;
#(
   parameter int          SCAN_CHUNKS = 16384,
   parameter int          ADDR_W      = 32,
   parameter logic [31:0] MAGIC_MAIN  = 32'h4E42_4F54,
   parameter logic [31:0] MAGIC_SAFE  = 32'h4E42_5346,
   localparam int         IDX_W       = (SCAN_CHUNKS > 1) ? $clog2(SCAN_CHUNKS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sel_failsafe,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [IDX_W-1:0]  rd_req_idx,
   input  logic              rd_byte_valid,
   input  logic [7:0]        rd_byte,
   input  logic              rd_byte_last,
   input  logic              rd_ecc_corr,
   input  logic              rd_ecc_fail,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] entry_addr,
   output logic              on_failsafe,
   output logic              evt_corrected,
   output logic              evt_bad_block,
   output logic              evt_crc_err
);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SCAN_CHUNKS - 1);
   localparam int               FLUSH_N   = 8;   // bytes that precede a known load address
   localparam int               FL_W      = $clog2(FLUSH_N);
   localparam logic [31:0]      CHUNK_INC = 32'(CHUNK_BYTES);

   if (SCAN_CHUNKS < 1) begin : g_bad_window
      $error("boot_image_scan: SCAN_CHUNKS must be at least 1");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("boot_image_scan: ADDR_W must be 8..32");
   end

   scan_st_e         st;
   logic             mode_load;
   logic             done_q, fail_q, safe_q;
   logic [IDX_W-1:0] chunk_idx;
   logic [7:0]       pos;
   logic [31:0]      base;
   logic [FL_W-1:0]  flush_cnt;
   logic             corr_q, bad_q;
   logic [ADDR_W-1:0] entry_q;

   logic [8*HDR_BYTES-1:0] hdr_raw;
   img_hdr_t         hdr;
   logic [31:0]      crc_q;
   logic [31:0]      cur_idx;
   logic [31:0]      cur_magic;
   logic             hdr_ok;
   logic             crc_en, crc_clr, hdr_en;
   logic [31:0]      wr_full;

   assign hdr       = img_hdr_t'(hdr_raw);
   assign cur_idx   = base + {24'd0, pos};
   assign cur_magic = safe_q ? MAGIC_SAFE : MAGIC_MAIN;
   assign hdr_ok    = (hdr.magic == cur_magic) && (hdr.len != 32'd0);

   assign hdr_en  = (st == ST_STREAM) && rd_byte_valid && !mode_load && (pos < 8'(HDR_BYTES));
   assign crc_en  = (st == ST_STREAM) && rd_byte_valid &&
                    (cur_idx >= 32'(HDR_BYTES)) && (cur_idx < hdr.len);
   assign crc_clr = (st == ST_REQ) && !mode_load;

   scan_hdr_latch u_hdr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (hdr_en),
      .pos   (pos[3:0]),
      .din   (rd_byte),
      .raw   (hdr_raw)
   );

   scan_crc32 #(.BITS_PER_STEP(8)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (rd_byte),
      .crc_q (crc_q)
   );

   // memory port: streamed bytes, or the held-back header bytes
   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = 8'd0;
      wr_full   = 32'd0;
      if (st == ST_STREAM && rd_byte_valid) begin
         mem_wdata = rd_byte;
         wr_full   = hdr.load + cur_idx;
         if (mode_load)
            mem_we = 1'b1;
         else if (pos >= 8'(FLUSH_N) && hdr.magic == cur_magic)
            mem_we = 1'b1;
      end else if (st == ST_FLUSH) begin
         mem_we    = 1'b1;
         mem_wdata = hdr_raw[flush_cnt*8 +: 8];
         wr_full   = hdr.load + 32'(flush_cnt);
      end
   end
   assign mem_addr = wr_full[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         mode_load     <= 1'b0;
         done_q        <= 1'b0;
         fail_q        <= 1'b0;
         safe_q        <= 1'b0;
         chunk_idx     <= '0;
         pos           <= '0;
         base          <= '0;
         flush_cnt     <= '0;
         corr_q        <= 1'b0;
         bad_q         <= 1'b0;
         entry_q       <= '0;
         evt_corrected <= 1'b0;
         evt_bad_block <= 1'b0;
         evt_crc_err   <= 1'b0;
      end else begin
         evt_corrected <= 1'b0;
         evt_bad_block <= 1'b0;
         evt_crc_err   <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               safe_q    <= sel_failsafe;
               chunk_idx <= '0;
               mode_load <= 1'b0;
               base      <= '0;
               st        <= ST_REQ;
            end
            ST_REQ: if (rd_req_ready) begin
               pos <= '0;
               st  <= ST_STREAM;
            end
            ST_STREAM: if (rd_byte_valid) begin
               pos <= pos + 8'd1;
               if (rd_byte_last) begin
                  corr_q <= rd_ecc_corr;
                  bad_q  <= rd_ecc_fail;
                  st     <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (bad_q) begin
                  evt_bad_block <= mode_load;
                  mode_load     <= 1'b0;
                  base          <= '0;
                  st            <= ST_NEXT;
               end else begin
                  evt_corrected <= corr_q;
                  if (!mode_load) begin
                     if (hdr_ok) begin
                        mode_load <= 1'b1;
                        base      <= CHUNK_INC;
                        flush_cnt <= '0;
                        st        <= ST_FLUSH;
                     end else begin
                        st <= ST_NEXT;
                     end
                  end else begin
                     base <= base + CHUNK_INC;
                     st   <= ST_COMMIT;
                  end
               end
            end
            ST_FLUSH: begin
               flush_cnt <= flush_cnt + FL_W'(1);
               if (flush_cnt == FL_W'(FLUSH_N - 1)) st <= ST_COMMIT;
            end
            ST_COMMIT: begin
               if (base >= hdr.len) begin
                  if (~crc_q == hdr.crc) begin
                     done_q  <= 1'b1;
                     entry_q <= hdr.load[ADDR_W-1:0];
                     st      <= ST_HALT;
                  end else begin
                     evt_crc_err <= 1'b1;
                     mode_load   <= 1'b0;
                     base        <= '0;
                     st          <= ST_NEXT;
                  end
               end else begin
                  st <= ST_NEXT;
               end
            end
            ST_NEXT: begin
               if (chunk_idx == LAST_IDX) begin
                  mode_load <= 1'b0;
                  base      <= '0;
                  if (!safe_q) begin
                     safe_q    <= 1'b1;
                     chunk_idx <= '0;
                     st        <= ST_REQ;
                  end else begin
                     fail_q <= 1'b1;
                     st     <= ST_HALT;
                  end
               end else begin
                  chunk_idx <= chunk_idx + IDX_W'(1);
                  st        <= ST_REQ;
               end
            end
            ST_HALT: st <= ST_HALT;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_valid = (st == ST_REQ);
   assign rd_req_idx   = chunk_idx;
   assign busy         = (st != ST_IDLE) && (st != ST_HALT);
   assign done         = done_q;
   assign fail         = fail_q;
   assign entry_addr   = entry_q;
   assign on_failsafe  = safe_q;

   // R6 and R11: the two outcomes exclude each other
   a_r6_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> fail && !rd_req_valid);

   a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && $stable(entry_addr) && !rd_req_valid);

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_idx));

   a_r10_idx_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_idx <= LAST_IDX));

   a_r8_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_bad_block |=> !evt_bad_block);

   a_r7_crc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_crc_err |=> !evt_crc_err && !done);

   a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> !mem_we);
endmodule

// File: tb/boot_image_scan_test.sv
module boot_image_scan_test;
   localparam int CH = 12;
   localparam int IW = $clog2(CH);
   localparam logic [31:0] MG_MAIN = 32'h4E42_4F54;
   localparam logic [31:0] MG_SAFE = 32'h4E42_5346;

   logic clk = 1'b0;
   logic rst_n;
   logic start, sel_failsafe;
   logic rd_req_valid, rd_req_ready;
   logic [IW-1:0] rd_req_idx;
   logic rd_byte_valid, rd_byte_last, rd_ecc_corr, rd_ecc_fail;
   logic [7:0] rd_byte;
   logic mem_we;
   logic [31:0] mem_addr;
   logic [7:0] mem_wdata;
   logic busy, done, fail, on_failsafe;
   logic [31:0] entry_addr;
   logic evt_corrected, evt_bad_block, evt_crc_err;

   always #10 clk = ~clk;

   boot_image_scan #(
      .SCAN_CHUNKS(CH), .ADDR_W(32), .MAGIC_MAIN(MG_MAIN), .MAGIC_SAFE(MG_SAFE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .sel_failsafe(sel_failsafe),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_idx(rd_req_idx),
      .rd_byte_valid(rd_byte_valid), .rd_byte(rd_byte), .rd_byte_last(rd_byte_last),
      .rd_ecc_corr(rd_ecc_corr), .rd_ecc_fail(rd_ecc_fail),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .done(done), .fail(fail), .entry_addr(entry_addr),
      .on_failsafe(on_failsafe), .evt_corrected(evt_corrected),
      .evt_bad_block(evt_bad_block), .evt_crc_err(evt_crc_err)
   );

   logic [7:0] nand_b [0:CH*256-1];
   logic       nand_corr [0:CH-1];
   logic       nand_bad  [0:CH-1];
   logic [7:0] sink [0:4095];

   int n_cmp = 0;
   int n_bad = 0;

   // responder-owned observations
   int req_count, max_idx, last_idx, seq_err;
   // pulse counters
   int cnt_corr, cnt_bad, cnt_crc;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_ref(input int off, input int len);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 16; i < len; i++) begin
         c ^= {24'd0, nand_b[off+i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic wipe_nand();
      for (int i = 0; i < CH*256; i++) nand_b[i] = 8'($urandom);
      for (int i = 0; i < CH; i++) begin nand_corr[i] = 1'b0; nand_bad[i] = 1'b0; end
   endtask

   task automatic place(input int ch0, input logic [31:0] mg, input logic [31:0] load,
                        input int len, input bit spoil);
      int off = ch0*256;
      logic [31:0] c;
      for (int i = 0; i < 4; i++) begin
         nand_b[off+i]   = mg[8*i +: 8];
         nand_b[off+4+i] = load[8*i +: 8];
         nand_b[off+8+i] = 8'(len >> (8*i));
      end
      c = crc_ref(off, len);
      if (spoil) c ^= 32'h1;
      for (int i = 0; i < 4; i++) nand_b[off+12+i] = c[8*i +: 8];
   endtask

   task automatic chk_mem(input string req, input int ch0, input logic [31:0] load, input int len);
      int bad = 0;
      for (int i = 0; i < len; i++)
         if (sink[(load + 32'(i)) & 32'hFFF] !== nand_b[ch0*256+i]) bad++;
      chk(req, 64'(bad), 64'd0);
   endtask

   // memory sink, cleared during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) sink[i] <= 8'h00;
      end else if (mem_we) begin
         sink[mem_addr[11:0]] <= mem_wdata;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         cnt_corr = 0; cnt_bad = 0; cnt_crc = 0;
      end else begin
         cnt_corr += int'(evt_corrected);
         cnt_bad  += int'(evt_bad_block);
         cnt_crc  += int'(evt_crc_err);
      end
   end

   // chunk reader model
   initial begin
      int c;
      rd_req_ready = 1'b0; rd_byte_valid = 1'b0; rd_byte = 8'd0;
      rd_byte_last = 1'b0; rd_ecc_corr = 1'b0; rd_ecc_fail = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            req_count = 0; max_idx = -1; last_idx = -1; seq_err = 0;
         end else if (rd_req_valid) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            c = int'(rd_req_idx);
            if (!(c == 0 || c == last_idx + 1)) seq_err++;
            last_idx = c;
            if (c > max_idx) max_idx = c;
            req_count++;
            rd_req_ready = 1'b1;
            @(negedge clk);
            rd_req_ready = 1'b0;
            for (int i = 0; i < 256; i++) begin
               if ($urandom_range(0, 7) == 0) begin
                  rd_byte_valid = 1'b0;
                  @(negedge clk);
               end
               rd_byte_valid = 1'b1;
               rd_byte       = nand_b[c*256+i];
               rd_byte_last  = (i == 255);
               rd_ecc_corr   = (i == 255) && nand_corr[c];
               rd_ecc_fail   = (i == 255) && nand_bad[c];
               @(negedge clk);
            end
            rd_byte_valid = 1'b0; rd_byte_last = 1'b0;
            rd_ecc_corr = 1'b0; rd_ecc_fail = 1'b0;
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0; sel_failsafe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(input bit safe);
      sel_failsafe = safe; start = 1'b1;
      @(negedge clk);
      start = 1'b0; sel_failsafe = 1'b0;
      for (int t = 0; t < 30000 && !(done || fail); t++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int ch0, len, nch;
      logic [31:0] ld;
      bit sf;
      void'($urandom(32'd20240611));

      // R1 reset state
      wipe_nand();
      do_reset();
      chk("R1 busy", 64'(busy), 0);
      chk("R1 done/fail", 64'({done, fail}), 0);
      chk("R1 req/we", 64'({rd_req_valid, mem_we}), 0);
      chk("R1 events", 64'({evt_corrected, evt_bad_block, evt_crc_err}), 0);

      // R2 R3 R4 R5 R6: main image at chunk 2, three chunks
      wipe_nand(); place(2, MG_MAIN, 32'h100, 700, 0);
      do_reset(); run(0);
      chk("R6 done", 64'({done, fail}), 64'b10);
      chk("R6 entry", 64'(entry_addr), 64'h100);
      chk_mem("R3 R4 image copy", 2, 32'h100, 700);
      chk("R2 request count", 64'(req_count), 5);
      chk("R2 sequence", 64'(seq_err), 0);
      chk("R5 no crc error", 64'(cnt_crc), 0);

      // R9 corrected chunk inside image
      wipe_nand(); place(0, MG_MAIN, 32'h200, 600, 0); nand_corr[1] = 1'b1;
      do_reset(); run(0);
      chk("R9 done", 64'(done), 1);
      chk("R9 corrected pulses", 64'(cnt_corr), 1);
      chk_mem("R9 image copy", 0, 32'h200, 600);

      // R8 bad chunks: in hunting (skipped) and in loading (resync)
      wipe_nand();
      place(0, MG_MAIN, 32'h300, 512, 0); nand_bad[0] = 1'b1;
      place(2, MG_MAIN, 32'h200, 800, 0); nand_bad[4] = 1'b1;
      place(6, MG_MAIN, 32'h800, 300, 0);
      do_reset(); run(0);
      chk("R8 entry", 64'(entry_addr), 64'h800);
      chk("R8 bad pulses", 64'(cnt_bad), 1);
      chk_mem("R8 image copy", 6, 32'h800, 300);

      // R7 crc mismatch then good copy; R5 tail bytes past length are random
      wipe_nand();
      place(1, MG_MAIN, 32'h100, 520, 1);
      place(4, MG_MAIN, 32'h400, 530, 0);
      do_reset(); run(0);
      chk("R7 crc pulses", 64'(cnt_crc), 1);
      chk("R7 entry", 64'(entry_addr), 64'h400);
      chk_mem("R5 image copy", 4, 32'h400, 530);

      // R11 fallback to failsafe; R10 full window searched
      wipe_nand(); place(3, MG_SAFE, 32'h600, 256, 0);
      do_reset(); run(0);
      chk("R11 done on failsafe", 64'({done, on_failsafe}), 64'b11);
      chk("R11 entry", 64'(entry_addr), 64'h600);
      chk("R10 highest index", 64'(max_idx), CH-1);
      chk("R11 request count", 64'(req_count), CH+4);

      // R11 nothing found: fail, sticky, start ignored
      wipe_nand();
      do_reset(); run(0);
      chk("R11 fail", 64'({done, fail}), 64'b01);
      chk("R10 request count", 64'(req_count), 2*CH);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (50) @(negedge clk);
      chk("R11 start ignored", 64'({fail, busy, 8'(req_count)}), {2'b10, 8'(2*CH)});

      // R11 failsafe selected: main image ignored, one pass only
      wipe_nand(); place(0, MG_MAIN, 32'h100, 300, 0);
      do_reset(); run(1);
      chk("R11 selected failsafe fail", 64'({done, fail}), 64'b01);
      chk("R11 single pass", 64'(req_count), CH);

      // R3 R6 single-chunk image
      wipe_nand(); place(5, MG_MAIN, 32'hA00, 100, 0);
      do_reset(); run(0);
      chk("R6 short image", 64'({done, 32'(entry_addr)}), {1'b1, 32'hA00});
      chk("R3 request count", 64'(req_count), 6);
      chk_mem("R3 short copy", 5, 32'hA00, 100);

      // R10 image completes in the last chunk of the window
      wipe_nand(); place(CH-3, MG_MAIN, 32'h500, 768, 0);
      do_reset(); run(0);
      chk("R10 last chunk success", 64'({done, fail, on_failsafe}), 64'b100);
      chk("R10 request count", 64'(req_count), CH);

      // random images
      for (int it = 0; it < 5; it++) begin
         ch0 = $urandom_range(0, CH-1);
         nch = CH - ch0; if (nch > 3) nch = 3;
         len = $urandom_range(17, nch*256);
         ld  = 32'($urandom_range(0, 12)) * 32'h100;
         sf  = 1'($urandom_range(0, 1));
         wipe_nand(); place(ch0, sf ? MG_SAFE : MG_MAIN, ld, len, 0);
         do_reset(); run(sf);
         chk("R6 random done", 64'({done, 32'(entry_addr)}), {1'b1, ld});
         chk_mem("R4 random copy", ch0, ld, len);
      end

      finish_run();
   end
endmodule